// File: doc/BRIEF.md
# Programmable Two-Phase PWM Generator

This block produces a two-phase pulse waveform. Each period starts with a first phase of programmable length at a programmable level. The rest of the period is driven to the opposite level. The period length and the first-phase length come from 32-bit registers. Both values are copied into internal shadow copies when a run starts and again at every period boundary. A register write made in the middle of a period therefore only changes the next period. Outside a run, the output rests at a separately programmable idle level.

Three modes are available:
- Disabled: the output rests at the idle level.
- One-shot: the block emits an 8-bit repeat count plus one periods, then stops.
- Continuous: periods repeat until the mode is changed.

A start strobe launches a run. In one-shot mode the start strobe can instead arm an edge detector on a trigger input. The trigger is synchronised to the block clock, and only the first edge of the selected polarity starts the run. On completion of a one-shot run the block pulses an interrupt if that interrupt is enabled. Status outputs report the current output level, whether a run is in progress, and whether the block is waiting for a trigger.

Software drives the block through a simple write port with a 3-bit address. Address 0 holds the configuration, 1 the period value P, 2 the first-phase length H, 3 the repeat count N, and 4 the start strobe.

Top module: `dual_phase_pwm`

## Requirements
- R1: After reset, `pwm_out` and `st_level` are 0, and `st_busy`, `st_armed` and `irq_pulse` are 0.
- R2: While no run is in progress, `pwm_out` equals the idle-level bit, which is bit 3 of the word written to address 0.
- R3: A period lasts P+1 cycles, where P is the value written to address 1. For the first H cycles of the period (H written to address 2), the output equals the first-level bit, bit 2 of the configuration word. For the remaining cycles it is the inverse of that bit. If H is greater than P, the output holds the first level for the whole period. The first run cycle begins at the clock edge that registers the start write.
- R4: In one-shot mode (configuration bits [1:0] = 1), a run lasts exactly (N+1)·(P+1) cycles, where N is written to address 3. The block then returns to idle and does not restart without a new start write.
- R5: When a one-shot run completes and the interrupt-enable bit (configuration bit 4) is set, `irq_pulse` is high for exactly the single cycle after the last run cycle. When that bit is clear, `irq_pulse` stays low.
- R6: In continuous mode (configuration bits [1:0] = 2), periods repeat without end. New values written to P or H during a period are first used at the next period boundary.
- R7: Writing mode 0 forces `pwm_out` to the idle level, and `st_busy` to 0, from the very next cycle, even in the middle of a run. Writing a nonzero mode afterwards does not restart the block on its own.
- R8: A start strobe is a write to address 4 with data bit 0 set. When a start strobe arrives in one-shot mode with the trigger-enable bit (configuration bit 5) set, the block enters the armed state. In the armed state `st_armed` is 1 and the output is at the idle level. Configuration bit 6 selects the edge: 1 for rising, 0 for falling. If the selected edge of `trig_in` is present at clock edge T, the first run cycle begins at edge T+2.
- R9: Trigger edges of the opposite polarity while armed, edges during a run, and edges after completion are all ignored. None of them starts or restarts counting.
- R10: A start strobe is ignored while the mode is 0 or 3, and while a run is in progress. An ignored strobe leaves the output and the run length unchanged.
- R11: `st_level` always equals `pwm_out`, and `st_busy` is 1 exactly during run cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 cfg, 1 P, 2 H, 3 N, 4 start) |
| wr_data | input | 32 | Write data |
| trig_in | input | 1 | Asynchronous event-trigger input |
| pwm_out | output | 1 | Waveform output |
| irq_pulse | output | 1 | One-cycle completion interrupt |
| st_level | output | 1 | Current output level |
| st_busy | output | 1 | A run is in progress |
| st_armed | output | 1 | Waiting for the trigger edge |

## Verification
The bench sweeps small combinations of period, first-phase length and repeat count, and checks every cycle against values computed arithmetically. Off-by-one errors show up directly in this sweep. A counter that ends a period one cycle early or late shifts every later edge, and a first phase that wraps when H exceeds P produces a spurious inverse pulse.

In continuous mode the bench writes P and H in the middle of a period. A design without shadowing would distort the current period. A forced stop through mode 0 is checked in the very next cycle, which exposes an output that waits one cycle for the state machine.

The trigger tests check the two-cycle synchroniser latency, rejection of the wrong edge polarity, and the fact that later edges neither restart nor re-arm the block. A design that re-arms after the first edge would launch a second run.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

  localparam int unsigned CNT_W  = 32;
  localparam int unsigned RPT_W  = 8;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_ONCE = 2'd1,
    MODE_LOOP = 2'd2,
    MODE_RSVD = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2
  } run_state_e;

  // configuration word, bit 6 down to bit 0
  typedef struct packed {
    logic  edge_rise;
    logic  trig_en;
    logic  irq_en;
    logic  idle_lvl;
    logic  first_lvl;
    mode_e mode;
  } cfg_t;

  localparam logic [2:0] ADR_CFG = 3'd0;
  localparam logic [2:0] ADR_PER = 3'd1;
  localparam logic [2:0] ADR_PH1 = 3'd2;
  localparam logic [2:0] ADR_RPT = 3'd3;
  localparam logic [2:0] ADR_GO  = 3'd4;

endpackage

// File: rtl/dpwm_regs.sv
module dpwm_regs
  import dpwm_pkg::*;
#(
  parameter int unsigned CW = CNT_W,
  parameter int unsigned RW = RPT_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  output cfg_t          cfg_o,
  output logic [CW-1:0] per_o,
  output logic [CW-1:0] ph1_o,
  output logic [RW-1:0] rpt_o,
  output logic          go_o
);

  localparam int unsigned CFG_W = $bits(cfg_t);
  localparam logic [AW-1:0] A_CFG = AW'(ADR_CFG);
  localparam logic [AW-1:0] A_PER = AW'(ADR_PER);
  localparam logic [AW-1:0] A_PH1 = AW'(ADR_PH1);
  localparam logic [AW-1:0] A_RPT = AW'(ADR_RPT);
  localparam logic [AW-1:0] A_GO  = AW'(ADR_GO);

  logic cfg_en, per_en, ph1_en, rpt_en;
  cfg_t          cfg_q, cfg_d;
  logic [CW-1:0] per_q, ph1_q;
  logic [RW-1:0] rpt_q;

  always_comb begin
    cfg_en = wr_en && (wr_addr == A_CFG);
    per_en = wr_en && (wr_addr == A_PER);
    ph1_en = wr_en && (wr_addr == A_PH1);
    rpt_en = wr_en && (wr_addr == A_RPT);
    go_o   = wr_en && (wr_addr == A_GO) && wr_data[0];
    cfg_d  = cfg_t'(wr_data[CFG_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      per_q <= '0;
      ph1_q <= '0;
      rpt_q <= '0;
    end else begin
      if (cfg_en) cfg_q <= cfg_d;
      if (per_en) per_q <= wr_data;
      if (ph1_en) ph1_q <= wr_data;
      if (rpt_en) rpt_q <= wr_data[RW-1:0];
    end
  end

  assign cfg_o = cfg_q;
  assign per_o = per_q;
  assign ph1_o = ph1_q;
  assign rpt_o = rpt_q;

endmodule

// File: rtl/dpwm_edge_sync.sv
module dpwm_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise_o,
  output logic fall_o
);

  localparam int unsigned DEPTH = (STAGES < 2) ? 3 : STAGES + 1;
  localparam int unsigned SYNC  = DEPTH - 2;

  logic [DEPTH-1:0] chain_q, chain_d;

  always_comb begin
    chain_d = chain_q;
    chain_d[0] = din;
    for (int i = 1; i < DEPTH; i++) begin
      chain_d[i] = chain_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rise_o =  chain_q[SYNC] & ~chain_q[SYNC+1];
  assign fall_o = ~chain_q[SYNC] &  chain_q[SYNC+1];

endmodule

// File: rtl/dpwm_period_engine.sv
module dpwm_period_engine
  import dpwm_pkg::*;
#(
  parameter int unsigned CW = CNT_W,
  parameter int unsigned RW = RPT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch_i,
  input  logic          active_i,
  input  logic          once_i,
  input  logic [CW-1:0] per_i,
  input  logic [CW-1:0] ph1_i,
  input  logic [RW-1:0] rpt_i,
  output logic          in_first_o,
  output logic          period_end_o,
  output logic          series_done_o
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] per_sh_q, per_sh_d;
  logic [CW-1:0] ph1_sh_q, ph1_sh_d;
  logic [RW-1:0] rep_q, rep_d;
  logic          cnt_en;

  assign period_end_o  = active_i && (cnt_q == per_sh_q);
  assign series_done_o = period_end_o && once_i && (rep_q == '0);
  assign in_first_o    = (cnt_q < ph1_sh_q);

  always_comb begin
    cnt_en   = launch_i || active_i;
    cnt_d    = cnt_q;
    per_sh_d = per_sh_q;
    ph1_sh_d = ph1_sh_q;
    rep_d    = rep_q;
    if (launch_i) begin
      cnt_d    = '0;
      per_sh_d = per_i;
      ph1_sh_d = ph1_i;
      rep_d    = rpt_i;
    end else if (period_end_o) begin
      cnt_d    = '0;
      per_sh_d = per_i;
      ph1_sh_d = ph1_i;
      if (rep_q != '0) rep_d = rep_q - 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      per_sh_q <= '0;
      ph1_sh_q <= '0;
      rep_q    <= '0;
    end else if (cnt_en) begin
      cnt_q    <= cnt_d;
      per_sh_q <= per_sh_d;
      ph1_sh_q <= ph1_sh_d;
      rep_q    <= rep_d;
    end
  end

  // R3
  cnt_in_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_i |-> (cnt_q <= per_sh_q));

  // R6
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && !period_end_o) |=> ($stable(per_sh_q) && $stable(ph1_sh_q)));

  // R4
  rep_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && $past(active_i)) |-> (rep_q <= $past(rep_q)));

endmodule

// File: rtl/dual_phase_pwm.sv
module dual_phase_pwm
  import dpwm_pkg::*;
#(
  parameter int unsigned CW          = CNT_W,
  parameter int unsigned RW          = RPT_W,
  parameter int unsigned AW          = ADDR_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          trig_in,
  output logic          pwm_out,
  output logic          irq_pulse,
  output logic          st_level,
  output logic          st_busy,
  output logic          st_armed
);

  cfg_t          cfg;
  logic [CW-1:0] per_r, ph1_r;
  logic [RW-1:0] rpt_r;
  logic          go;
  logic          trig_rise, trig_fall, trig_hit;
  logic          in_first, period_end, series_done;
  logic          mode_off, once, launch, irq_d;
  run_state_e    state_q, state_d;
  logic          irq_q;

  dpwm_regs #(.CW(CW), .RW(RW), .AW(AW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .cfg_o   (cfg),
    .per_o   (per_r),
    .ph1_o   (ph1_r),
    .rpt_o   (rpt_r),
    .go_o    (go)
  );

  dpwm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    (trig_in),
    .rise_o (trig_rise),
    .fall_o (trig_fall)
  );

  dpwm_period_engine #(.CW(CW), .RW(RW)) u_engine (
    .clk           (clk),
    .rst_n         (rst_n),
    .launch_i      (launch),
    .active_i      (state_q == ST_RUN),
    .once_i        (once),
    .per_i         (per_r),
    .ph1_i         (ph1_r),
    .rpt_i         (rpt_r),
    .in_first_o    (in_first),
    .period_end_o  (period_end),
    .series_done_o (series_done)
  );

  assign mode_off = (cfg.mode == MODE_OFF) || (cfg.mode == MODE_RSVD);
  assign once     = (cfg.mode == MODE_ONCE);
  assign trig_hit = cfg.edge_rise ? trig_rise : trig_fall;

  always_comb begin
    state_d = state_q;
    launch  = 1'b0;
    irq_d   = 1'b0;
    if (mode_off) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (go) begin
            if (once && cfg.trig_en) begin
              state_d = ST_ARMED;
            end else begin
              state_d = ST_RUN;
              launch  = 1'b1;
            end
          end
        end
        ST_ARMED: begin
          if (trig_hit) begin
            state_d = ST_RUN;
            launch  = 1'b1;
          end
        end
        ST_RUN: begin
          if (series_done) begin
            state_d = ST_IDLE;
            irq_d   = cfg.irq_en;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      irq_q   <= irq_d;
    end
  end

  always_comb begin
    st_busy  = (state_q == ST_RUN) && !mode_off;
    st_armed = (state_q == ST_ARMED) && !mode_off;
    if (st_busy) pwm_out = in_first ? cfg.first_lvl : ~cfg.first_lvl;
    else         pwm_out = cfg.idle_lvl;
    st_level  = pwm_out;
    irq_pulse = irq_q;
  end

  // R7
  off_forces_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_off |=> (state_q == ST_IDLE));

  // R5
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);

  // R5
  irq_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> (!st_busy && $past(st_busy)));

  // R8
  trig_arm_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(st_busy) && once && cfg.trig_en) |-> $past(state_q == ST_ARMED));

endmodule

// File: tb/sim_dual_phase_pwm.sv
module sim_dual_phase_pwm;

  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] A_CFG = 3'd0, A_PER = 3'd1, A_PH1 = 3'd2,
                         A_RPT = 3'd3, A_GO = 3'd4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [31:0] wr_data;
  logic        trig_in;
  logic        pwm_out, irq_pulse, st_level, st_busy, st_armed;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_phase_pwm u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .trig_in(trig_in), .pwm_out(pwm_out),
    .irq_pulse(irq_pulse), .st_level(st_level), .st_busy(st_busy),
    .st_armed(st_armed)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [31:0] cfgw(input int mode, input logic first, input logic idle,
                                       input logic irq, input logic trg, input logic rise);
    return 32'(mode) | (32'(first) << 2) | (32'(idle) << 3) | (32'(irq) << 4)
         | (32'(trg) << 5) | (32'(rise) << 6);
  endfunction

  function automatic logic exp_lvl(input int j, input int per, input int ph1, input logic first);
    int pos;
    pos = j % (per + 1);
    return (pos < ph1) ? first : ~first;
  endfunction

  task automatic run_once(input int per, input int ph1, input int rpt,
                          input logic first, input logic idle, input logic irqen);
    int n;
    wr(A_CFG, cfgw(0, first, idle, irqen, 0, 0));
    wr(A_PER, 32'(per));
    wr(A_PH1, 32'(ph1));
    wr(A_RPT, 32'(rpt));
    wr(A_CFG, cfgw(1, first, idle, irqen, 0, 0));
    chk("R2 idle before start", pwm_out, idle);
    wr(A_GO, 32'd1);
    n = (rpt + 1) * (per + 1);
    for (int j = 0; j < n; j++) begin
      chk("R3 waveform", pwm_out, exp_lvl(j, per, ph1, first));
      chk("R11 busy", st_busy, 1'b1);
      chk("R11 level", st_level, pwm_out);
      @(negedge clk);
    end
    chk("R4 stop after series", st_busy, 1'b0);
    chk("R2 idle after run", pwm_out, idle);
    chk("R5 irq pulse", irq_pulse, irqen);
    @(negedge clk);
    chk("R5 irq one cycle", irq_pulse, 1'b0);
    chk("R4 no restart", st_busy, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R4: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; trig_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 out", pwm_out, 1'b0);
    chk("R1 level", st_level, 1'b0);
    chk("R1 busy", st_busy, 1'b0);
    chk("R1 armed", st_armed, 1'b0);
    chk("R1 irq", irq_pulse, 1'b0);

    // R3 R4 R5 sweep
    for (int per = 0; per < 5; per++)
      for (int ph1 = 0; ph1 < 7; ph1++)
        for (int rpt = 0; rpt < 3; rpt++)
          run_once(per, ph1, rpt, logic'((per + ph1) % 2), logic'(rpt % 2), logic'(ph1 % 2));

    // R6 continuous with mid-period parameter change, then R7 forced stop
    wr(A_PER, 32'd3);
    wr(A_PH1, 32'd1);
    wr(A_CFG, cfgw(2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0));
    wr(A_GO, 32'd1);
    for (int j = 0; j < 17; j++) begin
      if (j < 4) chk("R6 old period", pwm_out, exp_lvl(j, 3, 1, 1'b0));
      else       chk("R6 new period", pwm_out, exp_lvl(j - 4, 5, 4, 1'b0));
      chk("R6 busy", st_busy, 1'b1);
      if (j == 1)       begin wr_en = 1'b1; wr_addr = A_PER; wr_data = 32'd5; end
      else if (j == 2)  begin wr_en = 1'b1; wr_addr = A_PH1; wr_data = 32'd4; end
      else if (j == 16) begin wr_en = 1'b1; wr_addr = A_CFG;
                              wr_data = cfgw(0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0); end
      else wr_en = 1'b0;
      @(negedge clk);
    end
    wr_en = 1'b0;
    chk("R7 immediate idle", pwm_out, 1'b1);
    chk("R7 busy cleared", st_busy, 1'b0);
    chk("R5 no irq on abort", irq_pulse, 1'b0);
    wr(A_CFG, cfgw(2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0));
    repeat (3) @(negedge clk);
    chk("R7 no self restart", st_busy, 1'b0);
    chk("R7 stays idle", pwm_out, 1'b1);

    // R10 start ignored in mode 0 and mode 3
    wr(A_CFG, cfgw(0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
    wr(A_GO, 32'd1);
    chk("R10 mode0 start", st_busy, 1'b0);
    chk("R10 mode0 out", pwm_out, 1'b0);
    wr(A_CFG, cfgw(3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
    wr(A_GO, 32'd1);
    chk("R10 mode3 start", st_busy, 1'b0);
    chk("R10 mode3 out", pwm_out, 1'b0);

    // R10 start while busy does not extend the run
    wr(A_PER, 32'd3);
    wr(A_PH1, 32'd2);
    wr(A_RPT, 32'd1);
    wr(A_CFG, cfgw(1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0));
    wr(A_GO, 32'd1);
    for (int j = 0; j < 8; j++) begin
      chk("R10 busy run", pwm_out, exp_lvl(j, 3, 2, 1'b1));
      if (j == 2) begin wr_en = 1'b1; wr_addr = A_GO; wr_data = 32'd1; end
      else wr_en = 1'b0;
      @(negedge clk);
    end
    chk("R10 run length kept", st_busy, 1'b0);
    chk("R10 irq at end", irq_pulse, 1'b1);
    @(negedge clk);

    // R8 R9 rising-edge trigger
    wr(A_CFG, cfgw(1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1));
    wr(A_GO, 32'd1);
    chk("R8 armed", st_armed, 1'b1);
    chk("R8 armed idle out", pwm_out, 1'b0);
    repeat (3) @(negedge clk);
    chk("R8 waits for edge", st_busy, 1'b0);
    trig_in = 1'b1;
    @(negedge clk);
    chk("R8 latency T", st_busy, 1'b0);
    @(negedge clk);
    chk("R8 latency T+1", st_busy, 1'b0);
    @(negedge clk);
    for (int j = 0; j < 8; j++) begin
      chk("R8 triggered run", pwm_out, exp_lvl(j, 3, 2, 1'b1));
      chk("R8 busy", st_busy, 1'b1);
      trig_in = logic'(j % 2);
      @(negedge clk);
    end
    chk("R9 later edges ignored", st_busy, 1'b0);
    trig_in = 1'b0;
    repeat (2) @(negedge clk);
    trig_in = 1'b1;
    repeat (5) @(negedge clk);
    chk("R9 no re-arm busy", st_busy, 1'b0);
    chk("R9 no re-arm armed", st_armed, 1'b0);

    // R8 R9 falling-edge selection
    wr(A_CFG, cfgw(1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0));
    trig_in = 1'b0;
    repeat (4) @(negedge clk);
    wr(A_GO, 32'd1);
    trig_in = 1'b1;
    repeat (5) @(negedge clk);
    chk("R9 wrong polarity ignored", st_busy, 1'b0);
    chk("R9 still armed", st_armed, 1'b1);
    trig_in = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 falling start", st_busy, 1'b1);
    chk("R8 falling first cycle", pwm_out, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule